// File: doc/BRIEF.md
# Digital Downconverter with Numerically Controlled Oscillator

This block moves a band of interest from a real intermediate frequency down to complex baseband. Every accepted input sample is multiplied by a quadrature pair, cosine for the in-phase path and sine for the quadrature path. The pair comes from a 32-bit phase accumulator that addresses a quarter-wave sine table. The mixed samples fill an eight-tap symmetric lowpass delay line. The filter is evaluated only once per D accepted samples, so the chosen decimation factor sets both the output rate and the bandwidth kept.

The tuning word is the phase step per input sample. Output frequency is tune_word / 2^32 times the input sample rate. The tuning word may change at any time. The oscillator phase is never restarted except by reset, so a retune bends the waveform without a jump.

Top module: `ddc_core`

## Requirements
- R1: While reset is low, and right after it is released, out_valid is 0 and out_i and out_q are 0. Reset also returns the oscillator phase, the filter delay line and the decimation count to zero.
- R2: The 12 most significant phase bits address the sine. A quarter-wave table with amplitude 32767 supplies it, with sin(0)=0 and sin(90°)=32767. Cosine is the sine of the phase plus 90°. The in-phase product is sample×cos and the quadrature product is sample×sin.
- R3: The filter taps, from newest to oldest, are 1,3,5,7,7,5,3,1. Each output is floor(S/2^17 + 1/2), where S is the weighted tap sum of the products. With a zero tuning word and a steady input x, this makes out_i equal to round(x·32767/4096) and out_q equal to 0.
- R4: An output that falls outside the signed 16-bit range is clamped to 32767 or -32768.
- R5: Take a tuning word of 0x40000000 and an input tone x, 0, -x, 0, … that starts at phase zero. This tone is shifted to DC: out_i = round(x·32767/8192) and out_q = 0.
- R6: Tones at a quarter or a half of the sample rate (tuning words 0x40000000 and 0x80000000) on a steady input give out_i = out_q = 0 once the delay line is full.
- R7: out_valid is a one-cycle pulse, raised on exactly one output per D accepted samples. It rises in the cycle after the clock edge that accepts the D-th sample.
- R8: A decimation value below 2 acts as 2. A value above 16 acts as 16.
- R9: A cycle with in_valid low changes neither the phase, the delay line nor the count. The in_sample value in such a cycle has no effect on any output.
- R10: A new tuning word applies from the next accepted sample onward, and the accumulated phase is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_sample is accepted this cycle |
| in_sample | input | 14 | Signed real IF sample |
| tune_word | input | 32 | Phase increment per accepted sample |
| decim | input | 5 | Decimation factor, 2..16 |
| out_valid | output | 1 | out_i/out_q hold a new result |
| out_i | output | 16 | Signed in-phase output |
| out_q | output | 16 | Signed quadrature output |

## Verification
Two things can happen in the same clock cycle: the filter evaluates and registers a decimated result, and a new sample shifts into the delay line that the result is read from. The bench provokes this with D=2 and samples on every cycle. It then checks that the steady result still matches the value computed from the taps and gain. A second case joins a retune with an ongoing phase. The bench checks the quadrature output after switching from a quarter-rate step to a zero step: full scale on Q and zero on I shows that the phase was carried over rather than reset.

// File: rtl/ddc_core.sv
module ddc_core #(
  parameter int IW   = 14,
  parameter int OW   = 16,
  parameter int PW   = 32,
  parameter int AW   = 12,
  parameter int CW   = 16,
  parameter int NT   = 8,
  parameter int DMAX = 16,
  parameter int GSH  = 12,
  parameter int DW   = $clog2(DMAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] in_sample,
  input  logic        [PW-1:0] tune_word,
  input  logic        [DW-1:0] decim,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_i,
  output logic signed [OW-1:0] out_q
);
  localparam int  QA    = AW - 2;
  localparam int  QN    = 1 << QA;
  localparam int  AMP   = (1 << (CW - 1)) - 1;
  localparam int  MW    = IW + CW;
  localparam int  AccW  = MW + 2 * $clog2(NT) + 2;
  localparam int  SUMSH = $clog2(NT * NT / 2);
  localparam int  TOT   = SUMSH + GSH;
  localparam real PI    = 3.14159265358979;
  localparam logic signed [AccW-1:0] OMAX = AccW'((1 <<< (OW - 1)) - 1);
  localparam logic signed [AccW-1:0] OMIN = -OMAX - AccW'(1);

  logic signed [CW-1:0] qrom [QN];
  initial begin
    for (int a = 0; a < QN; a++)
      qrom[a] = CW'($rtoi($floor(AMP * $sin(PI * a / (2.0 * QN)) + 0.5)));
  end

  logic [PW-1:0] phase;
  logic [DW-1:0] cnt, dlim;
  logic          fire;
  logic [AW-1:0] pa [2];
  logic signed [CW-1:0] wav [2];
  logic signed [MW-1:0] mx_i, mx_q;
  logic signed [MW-1:0] ti [NT];
  logic signed [MW-1:0] tq [NT];
  logic signed [AccW-1:0] acc_i, acc_q;

  assign pa[0] = phase[PW-1 -: AW];
  assign pa[1] = phase[PW-1 -: AW] + AW'(QN);

  for (genvar k = 0; k < 2; k++) begin : g_lut
    logic [QA-1:0] a, ar;
    logic signed [CW-1:0] mag;
    assign a   = pa[k][QA-1:0];
    assign ar  = -a;
    assign mag = !pa[k][QA] ? qrom[a] : ((a == '0) ? CW'(AMP) : qrom[ar]);
    assign wav[k] = pa[k][QA+1] ? -mag : mag;
  end

  assign mx_i = MW'(in_sample) * MW'(wav[1]);
  assign mx_q = MW'(in_sample) * MW'(wav[0]);

  assign dlim = (decim < DW'(2)) ? DW'(2) : ((decim > DW'(DMAX)) ? DW'(DMAX) : decim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      cnt   <= '0;
      fire  <= 1'b0;
      for (int k = 0; k < NT; k++) begin
        ti[k] <= '0;
        tq[k] <= '0;
      end
    end else if (in_valid) begin
      phase <= phase + tune_word;
      ti[0] <= mx_i;
      tq[0] <= mx_q;
      for (int k = 1; k < NT; k++) begin
        ti[k] <= ti[k-1];
        tq[k] <= tq[k-1];
      end
      if (cnt >= dlim - DW'(1)) begin
        cnt  <= '0;
        fire <= 1'b1;
      end else begin
        cnt  <= cnt + DW'(1);
        fire <= 1'b0;
      end
    end else begin
      fire <= 1'b0;
    end
  end

  always_comb begin
    acc_i = '0;
    acc_q = '0;
    for (int k = 0; k < NT / 2; k++) begin
      acc_i = acc_i + (AccW'(ti[k]) + AccW'(ti[NT-1-k])) * AccW'(2 * k + 1);
      acc_q = acc_q + (AccW'(tq[k]) + AccW'(tq[NT-1-k])) * AccW'(2 * k + 1);
    end
  end

  function automatic logic signed [OW-1:0] rsat(input logic signed [AccW-1:0] v);
    logic signed [AccW-1:0] r;
    r = (v + (AccW'(1) <<< (TOT - 1))) >>> TOT;
    if (r > OMAX)      r = OMAX;
    else if (r < OMIN) r = OMIN;
    return r[OW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_i <= rsat(acc_i);
        out_q <= rsat(acc_q);
      end
    end
  end

  p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));
  p_hold_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(phase));
  p_hold_taps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(ti[0]) && $stable(tq[NT-1])));
  p_hold_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt));
endmodule

// File: tb/test_ddc_core.sv
module test_ddc_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [13:0] in_sample = '0;
  logic [31:0] tune_word = '0;
  logic [4:0] decim = 5'd4;
  logic out_valid;
  logic signed [15:0] out_i, out_q;

  int checks = 0, errors = 0, nout = 0, last_i = 0, last_q = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  ddc_core i_ddc_core (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .tune_word(tune_word), .decim(decim), .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

  always @(negedge clk) if (out_valid) begin
    nout++;
    last_i = int'(out_i);
    last_q = int'(out_q);
  end

  localparam int NV = 9;
  // mode 0: steady input, mode 1: quarter-rate tone x,0,-x,0
  localparam logic [31:0] V_TUNE [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h40000000,
                                          32'h40000000, 32'h80000000, 32'h0, 32'h0};
  localparam int V_DEC  [NV] = '{4, 8, 2, 16, 4, 3, 5, 0, 31};
  localparam int V_MODE [NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 0};
  localparam int V_X    [NV] = '{4000, -1000, 8191, -8192, 4000, 4000, 4000, 1, 0};
  localparam int V_GAP  [NV] = '{0, 1, 0, 1, 0, 1, 0, 0, 0};
  localparam int V_EI   [NV] = '{31999, -8000, 32767, -32768, 16000, 0, 0, 8, 0};
  localparam int V_EQ   [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0};
  localparam int V_ECNT [NV] = '{8, 4, 16, 2, 8, 10, 6, 16, 2};
  // rows: 0 R3 | 1 R3 R9 | 2 R4 | 3 R4 R9 | 4 R5 | 5 R6 R9 | 6 R6 | 7 R8 | 8 R8
  localparam string V_REQ [NV] = '{"R3", "R3/R9", "R4", "R4/R9", "R5", "R6/R9", "R6", "R8", "R8"};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input int x, input bit gap);
    if (gap) begin
      in_valid = 1'b0;
      in_sample = 14'sh1555;
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_sample = 14'(x);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    int base;
    repeat (2) @(negedge clk);
    chk("R1", int'(out_valid), 0);
    do_reset();
    chk("R1", int'(out_valid), 0);
    chk("R1", int'(out_i), 0);
    chk("R1", int'(out_q), 0);

    for (int r = 0; r < NV; r++) begin
      do_reset();
      tune_word = V_TUNE[r];
      decim = 5'(V_DEC[r]);
      base = nout;
      for (int n = 0; n < 32; n++) begin
        int x;
        if (V_MODE[r] == 0) x = V_X[r];
        else x = (n % 4 == 0) ? V_X[r] : ((n % 4 == 2) ? -V_X[r] : 0);
        push(x, V_GAP[r] != 0);
      end
      repeat (4) @(negedge clk);
      chk($sformatf("%s row %0d I", V_REQ[r], r), last_i, V_EI[r]);
      chk($sformatf("%s row %0d Q", V_REQ[r], r), last_q, V_EQ[r]);
      chk($sformatf("R7 row %0d pulses", r), nout - base, V_ECNT[r]);
    end

    // R10 and R2: retune after one quarter-rate step keeps phase at 90 degrees
    do_reset();
    tune_word = 32'h40000000;
    decim = 5'd8;
    push(0, 1'b0);
    tune_word = 32'h0;
    for (int n = 0; n < 31; n++) push(4000, 1'b0);
    repeat (4) @(negedge clk);
    chk("R10 I after retune", last_i, 0);
    chk("R10 Q after retune (R2 sin90)", last_q, 31999);

    // R1: reset clears a nonzero output
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 out_q in reset", int'(out_q), 0);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_q after reset", int'(out_q), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule